// File: doc/BRIEF.md
# Zero-Address Detection Event Unit

This unit watches the operand address registers of the instruction being executed and raises a program event when an operand is addressed through a register that holds zero. The instruction decoder presents a check strobe together with the address and length register values and a check mode. The mode selects how the zero test is qualified: unconditional, gated by a nonzero full-width length, gated by a nonzero low 24 bits of the length, or qualified by base and index register numbers.

A detected zero address is dropped when the unit is disabled or when suppression applies. Suppression applies to suppressible event classes while a transaction is in progress. It also applies to instruction-fetch events raised by the two transaction-begin opcodes. When an event is raised, the unit drives a one-cycle registered pulse and latches the current instruction address so that the interrupt logic can report it. Delivery of the event to the processor is handled outside this unit.

Top module: `zad_event_unit`

## Requirements
- R1: After reset, `event_o` is 0 and `event_addr_o` is 0.
- R2: Mode 0 (plain): a hit occurs when `addr_a_i` is zero, or when `two_op_i` is 1 and `addr_b_i` is zero.
- R3: Mode 1 (full length): operand A hits when `addr_a_i` is zero and any bit of `len_a_i` is set, including bits above bit 23. Operand B follows the same rule with `len_b_i` and counts only when `two_op_i` is 1.
- R4: Mode 2 (short length): like mode 1, except that only bits [23:0] of each length value decide whether the length is nonzero.
- R5: Mode 3 (base/index): `addr_a_i` carries the base value and `addr_b_i` carries the index value, and `two_op_i` is ignored. A register number of zero marks that register as unused, so it never hits. With only the base used, a hit means the base is zero. With only the index used, a hit means the index is zero. With both used, a hit means the base is zero or the sum base+index, truncated to ADDR_W bits, is zero.
- R6: No event is raised while `zad_en_i` is 0.
- R7: A hit is suppressed when `supp_en_i`, `supp_class_i` and `txn_active_i` are all 1.
- R8: A hit is suppressed when `supp_en_i`, `supp_class_i` and `ifetch_class_i` are 1 and the opcode bytes are 0xE5 followed by 0x60 or 0x61. Any other second byte does not suppress.
- R9: `event_o` is high for exactly one cycle, in the cycle after a clock edge at which `chk_valid_i` was 1 and an unsuppressed, enabled hit existed. Without a strobe, no event occurs. Back-to-back strobes each produce their own result.
- R10: On an event, `event_addr_o` takes the value of `inst_addr_i` sampled with the strobe. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_valid_i | input | 1 | Check strobe |
| chk_mode_i | input | 2 | 0 plain, 1 full length, 2 short length, 3 base/index |
| two_op_i | input | 1 | Second operand present (modes 0-2) |
| addr_a_i | input | ADDR_W | Operand A address register / base value |
| addr_b_i | input | ADDR_W | Operand B address register / index value |
| len_a_i | input | ADDR_W | Operand A length register |
| len_b_i | input | ADDR_W | Operand B length register |
| base_num_i | input | NUM_W | Base register number |
| index_num_i | input | NUM_W | Index register number |
| zad_en_i | input | 1 | Zero-address event enable |
| supp_en_i | input | 1 | Event suppression control |
| supp_class_i | input | 1 | Event belongs to a suppressible class |
| ifetch_class_i | input | 1 | Event is of the instruction-fetch class |
| txn_active_i | input | 1 | Transaction in progress |
| opc_hi_i | input | 8 | First opcode byte |
| opc_lo_i | input | 8 | Second opcode byte |
| inst_addr_i | input | IA_W | Current instruction address |
| event_o | output | 1 | Registered event pulse |
| event_addr_o | output | IA_W | Latched event address |

## Verification
The assertions check the rules that hold on every cycle. An event pulse always traces back to a strobe taken with the enable set, with no transaction suppression and no opcode suppression. The latched address equals the instruction address sampled with that strobe and does not move between events. A strobe in base/index mode with both register numbers zero, or in short-length mode with both low length fields zero, is never followed by a pulse. The detection results per mode can only be shown by the bench scenarios. These include the length bits above bit 23, the wrap of base+index to zero, the lone index, the second operand gated by its flag, the opcode pairs that do or do not suppress, and back-to-back strobes.

// File: rtl/zad_pkg.sv
package zad_pkg;
  typedef enum logic [1:0] {
    CHK_PLAIN = 2'd0,
    CHK_LEN   = 2'd1,
    CHK_LEN24 = 2'd2,
    CHK_BX    = 2'd3
  } chk_mode_e;

  localparam int unsigned NUM_OPS     = 2;
  localparam int unsigned SHORT_LEN_W = 24;
  localparam logic [7:0]  TXN_OPC_HI  = 8'hE5;
  localparam logic [7:0]  TXN_OPC_LO0 = 8'h60;
  localparam logic [7:0]  TXN_OPC_LO1 = 8'h61;
endpackage

// File: rtl/zad_detect.sv
module zad_detect
  import zad_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned NUM_W  = 4
) (
  input  chk_mode_e               mode_i,
  input  logic                    two_op_i,
  input  logic [NUM_OPS-1:0][ADDR_W-1:0] addr_i,
  input  logic [NUM_OPS-1:0][ADDR_W-1:0] len_i,
  input  logic [NUM_W-1:0]        base_num_i,
  input  logic [NUM_W-1:0]        index_num_i,
  output logic                    hit_o
);
  localparam int unsigned SL_W = (SHORT_LEN_W < ADDR_W) ? SHORT_LEN_W : ADDR_W;

  logic [NUM_OPS-1:0] op_zero, len_hit, len24_hit;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic op_used;
    if (g == 0) begin : g_first
      assign op_used = 1'b1;
    end else begin : g_rest
      assign op_used = two_op_i;
    end
    assign op_zero[g]   = op_used && (addr_i[g] == '0);
    assign len_hit[g]   = op_zero[g] && (len_i[g] != '0);
    assign len24_hit[g] = op_zero[g] && (len_i[g][SL_W-1:0] != '0);
  end

  logic              base_used, index_used, bx_hit;
  logic [ADDR_W-1:0] bx_sum;

  assign base_used  = (base_num_i != '0);
  assign index_used = (index_num_i != '0);
  assign bx_sum     = addr_i[0] + addr_i[1];  // wraps at ADDR_W

  always_comb begin
    unique case ({base_used, index_used})
      2'b10:   bx_hit = (addr_i[0] == '0);
      2'b01:   bx_hit = (addr_i[1] == '0);
      2'b11:   bx_hit = (addr_i[0] == '0) || (bx_sum == '0);
      default: bx_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      CHK_PLAIN: hit_o = |op_zero;
      CHK_LEN:   hit_o = |len_hit;
      CHK_LEN24: hit_o = |len24_hit;
      CHK_BX:    hit_o = bx_hit;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/zad_suppress.sv
module zad_suppress
  import zad_pkg::*;
(
  input  logic       supp_en_i,
  input  logic       supp_class_i,
  input  logic       txn_active_i,
  input  logic       ifetch_class_i,
  input  logic [7:0] opc_hi_i,
  input  logic [7:0] opc_lo_i,
  output logic       suppress_o
);
  logic txn_begin_op;

  assign txn_begin_op = (opc_hi_i == TXN_OPC_HI) &&
                        ((opc_lo_i == TXN_OPC_LO0) || (opc_lo_i == TXN_OPC_LO1));

  assign suppress_o = supp_en_i && supp_class_i &&
                      (txn_active_i || (ifetch_class_i && txn_begin_op));
endmodule

// File: rtl/zad_event_unit.sv
module zad_event_unit
  import zad_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned NUM_W  = 4,
  parameter int unsigned IA_W   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_valid_i,
  input  logic [1:0]        chk_mode_i,
  input  logic              two_op_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [ADDR_W-1:0] len_a_i,
  input  logic [ADDR_W-1:0] len_b_i,
  input  logic [NUM_W-1:0]  base_num_i,
  input  logic [NUM_W-1:0]  index_num_i,
  input  logic              zad_en_i,
  input  logic              supp_en_i,
  input  logic              supp_class_i,
  input  logic              ifetch_class_i,
  input  logic              txn_active_i,
  input  logic [7:0]        opc_hi_i,
  input  logic [7:0]        opc_lo_i,
  input  logic [IA_W-1:0]   inst_addr_i,
  output logic              event_o,
  output logic [IA_W-1:0]   event_addr_o
);
  logic hit, suppress, fire;
  logic [NUM_OPS-1:0][ADDR_W-1:0] addr_v, len_v;

  assign addr_v = {addr_b_i, addr_a_i};
  assign len_v  = {len_b_i, len_a_i};

  zad_detect #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) u_detect (
    .mode_i      (chk_mode_e'(chk_mode_i)),
    .two_op_i    (two_op_i),
    .addr_i      (addr_v),
    .len_i       (len_v),
    .base_num_i  (base_num_i),
    .index_num_i (index_num_i),
    .hit_o       (hit)
  );

  zad_suppress u_suppress (
    .supp_en_i      (supp_en_i),
    .supp_class_i   (supp_class_i),
    .txn_active_i   (txn_active_i),
    .ifetch_class_i (ifetch_class_i),
    .opc_hi_i       (opc_hi_i),
    .opc_lo_i       (opc_lo_i),
    .suppress_o     (suppress)
  );

  assign fire = chk_valid_i && zad_en_i && hit && !suppress;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      event_o      <= 1'b0;
      event_addr_o <= '0;
    end else begin
      event_o <= fire;
      if (fire) event_addr_o <= inst_addr_i;
    end
  end

  assert_event_needs_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(chk_valid_i));

  assert_event_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(zad_en_i));

  assert_txn_suppress_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> !$past(supp_en_i && supp_class_i && txn_active_i));

  assert_opcode_suppress_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> !$past(supp_en_i && supp_class_i && ifetch_class_i &&
                       opc_hi_i == 8'hE5 && (opc_lo_i == 8'h60 || opc_lo_i == 8'h61)));

  assert_capture_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> (event_addr_o == $past(inst_addr_i)));

  assert_hold_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_o |-> $stable(event_addr_o));

  assert_unused_regs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && chk_mode_i == 2'd3 && base_num_i == '0 && index_num_i == '0)
      |=> !event_o);

  assert_short_len_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && chk_mode_i == 2'd2 && len_a_i[23:0] == '0 && len_b_i[23:0] == '0)
      |=> !event_o);
endmodule

// File: tb/sim_zad_event_unit.sv
`timescale 1ns/1ps
module sim_zad_event_unit;
  typedef struct {
    logic [1:0]  mode;
    logic        two;
    logic [63:0] a, b, la, lb;
    logic [3:0]  bn, xn;
    logic        en, se, sc, ifc, tx;
    logic [7:0]  op0, op1;
    logic [63:0] ia;
  } stim_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, two = 1'b0, en = 1'b0, se = 1'b0, sc = 1'b0, ifc = 1'b0, tx = 1'b0;
  logic [1:0]  mode = '0;
  logic [63:0] a = '0, b = '0, la = '0, lb = '0, ia = '0;
  logic [3:0]  bn = '0, xn = '0;
  logic [7:0]  op0 = '0, op1 = '0;
  logic        ev;
  logic [63:0] ev_addr;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  stim_t st;
  logic [63:0] exp_addr = '0;
  bit          q_ev[$];
  logic [63:0] q_addr[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  zad_event_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .chk_valid_i(valid), .chk_mode_i(mode),
    .two_op_i(two), .addr_a_i(a), .addr_b_i(b), .len_a_i(la), .len_b_i(lb),
    .base_num_i(bn), .index_num_i(xn), .zad_en_i(en), .supp_en_i(se),
    .supp_class_i(sc), .ifetch_class_i(ifc), .txn_active_i(tx),
    .opc_hi_i(op0), .opc_lo_i(op1), .inst_addr_i(ia),
    .event_o(ev), .event_addr_o(ev_addr)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp, string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic bit model(stim_t s);
    bit hit, sup;
    logic [63:0] sum;
    sum = s.a + s.b;
    case (s.mode)
      2'd0: hit = (s.a == 0) || (s.two && s.b == 0);
      2'd1: hit = (s.a == 0 && s.la != 0) || (s.two && s.b == 0 && s.lb != 0);
      2'd2: hit = (s.a == 0 && s.la[23:0] != 0) || (s.two && s.b == 0 && s.lb[23:0] != 0);
      default: begin
        if (s.bn != 0 && s.xn != 0) hit = (s.a == 0) || (sum == 0);
        else if (s.bn != 0)         hit = (s.a == 0);
        else if (s.xn != 0)         hit = (s.b == 0);
        else                        hit = 0;
      end
    endcase
    sup = s.se && s.sc && (s.tx || (s.ifc && s.op0 == 8'hE5 && (s.op1 == 8'h60 || s.op1 == 8'h61)));
    return s.en && hit && !sup;
  endfunction

  task automatic base_stim(logic [1:0] m, logic [63:0] iav);
    st = '{mode: m, two: 0, a: 1, b: 1, la: 0, lb: 0, bn: 0, xn: 0, en: 1,
           se: 0, sc: 0, ifc: 0, tx: 0, op0: 0, op1: 0, ia: iav};
  endtask

  task automatic strobe(string tag);
    bit e;
    @(negedge clk);
    mode = st.mode; two = st.two; a = st.a; b = st.b; la = st.la; lb = st.lb;
    bn = st.bn; xn = st.xn; en = st.en; se = st.se; sc = st.sc; ifc = st.ifc;
    tx = st.tx; op0 = st.op0; op1 = st.op1; ia = st.ia; valid = 1'b1;
    e = model(st);
    if (e) exp_addr = st.ia;
    q_ev.push_back(e); q_addr.push_back(exp_addr); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (valid && rst_n) begin
        @(negedge clk);
        if (q_ev.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R9 scoreboard empty: got ev %0b expected none", ev);
        end else begin
          string t;
          bit e;
          logic [63:0] ad;
          e = q_ev.pop_front(); ad = q_addr.pop_front(); t = q_tag.pop_front();
          check(t, {63'd0, ev}, {63'd0, e}, "event");
          check(t, ev_addr, ad, "event_addr");
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {63'd0, ev}, 64'd0, "event after reset");
    check("R1", ev_addr, 64'd0, "addr after reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 plain
    base_stim(2'd0, 64'h1000); st.a = 0; strobe("R2 a zero"); idle();
    base_stim(2'd0, 64'h1004); st.a = 5; st.b = 0; strobe("R2 b unused"); idle();
    base_stim(2'd0, 64'h1008); st.a = 5; st.b = 0; st.two = 1; strobe("R2 b zero"); idle();
    // R3 full length
    base_stim(2'd1, 64'h2000); st.a = 0; strobe("R3 len zero"); idle();
    base_stim(2'd1, 64'h2004); st.a = 0; st.la = 64'h1 << 40; strobe("R3 high len bit"); idle();
    base_stim(2'd1, 64'h2008); st.two = 1; st.b = 0; st.lb = 3; strobe("R3 op b"); idle();
    // R4 short length
    base_stim(2'd2, 64'h3000); st.a = 0; st.la = 64'h1 << 40; strobe("R4 high ignored"); idle();
    base_stim(2'd2, 64'h3004); st.a = 0; st.la = 64'h80_0000; strobe("R4 bit23"); idle();
    base_stim(2'd2, 64'h3008); st.two = 1; st.la = 1; st.b = 0; st.lb = 1; strobe("R4 op b"); idle();
    // R5 base/index
    base_stim(2'd3, 64'h4000); st.a = 0; st.b = 0; st.two = 1; strobe("R5 none used"); idle();
    base_stim(2'd3, 64'h4004); st.bn = 3; st.a = 0; strobe("R5 base only"); idle();
    base_stim(2'd3, 64'h4008); st.xn = 2; st.b = 0; strobe("R5 index only"); idle();
    base_stim(2'd3, 64'h400c); st.xn = 2; st.b = 7; st.a = 0; strobe("R5 base unused"); idle();
    base_stim(2'd3, 64'h4010); st.bn = 1; st.xn = 2; st.a = 5; st.b = -64'sd5; strobe("R5 sum wraps"); idle();
    base_stim(2'd3, 64'h4014); st.bn = 1; st.xn = 2; st.a = 5; st.b = 6; strobe("R5 sum nonzero"); idle();
    base_stim(2'd3, 64'h4018); st.bn = 1; st.xn = 2; st.a = 0; st.b = 9; strobe("R5 base zero"); idle();
    // R6 enable
    base_stim(2'd0, 64'h5000); st.a = 0; st.en = 0; strobe("R6 disabled"); idle();
    // R7 transaction suppression
    base_stim(2'd0, 64'h6000); st.a = 0; st.se = 1; st.sc = 1; st.tx = 1; strobe("R7 suppressed"); idle();
    base_stim(2'd0, 64'h6004); st.a = 0; st.sc = 1; st.tx = 1; strobe("R7 control off"); idle();
    base_stim(2'd0, 64'h6008); st.a = 0; st.se = 1; st.tx = 1; strobe("R7 class off"); idle();
    // R8 opcode suppression
    base_stim(2'd0, 64'h7000); st.a = 0; st.se = 1; st.sc = 1; st.ifc = 1; st.op0 = 8'hE5; st.op1 = 8'h60;
    strobe("R8 E560"); idle();
    st.op1 = 8'h61; st.ia = 64'h7004; strobe("R8 E561"); idle();
    st.op1 = 8'h62; st.ia = 64'h7008; strobe("R8 E562"); idle();
    st.op1 = 8'h60; st.ifc = 0; st.ia = 64'h700c; strobe("R8 not ifetch"); idle();
    // R9 no strobe, then back-to-back
    @(negedge clk);
    valid = 0; mode = 0; a = 0; en = 1; se = 0; ia = 64'h8000;
    @(negedge clk);
    check("R9", {63'd0, ev}, 64'd0, "event without strobe");
    check("R10", ev_addr, exp_addr, "addr held without strobe");
    base_stim(2'd0, 64'h9000); st.a = 0; strobe("R9 b2b first");
    base_stim(2'd0, 64'h9004); st.a = 0; strobe("R9 b2b second");
    base_stim(2'd0, 64'h9008); st.a = 3; strobe("R10 hold after b2b");
    idle();
    repeat (4) @(negedge clk);
    check("R9", {63'd0, ev}, 64'd0, "event idle");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule